// File: doc/BRIEF.md
# GPIO Port with Grouped Interrupt Lines

This block is a memory-mapped general purpose I/O port for a parameterised number of 32-pin banks. The default is two banks, which gives 64 pins. Software sets each pin to drive or to sense. A driven pin follows its data-out bit or, when blink is enabled, a shared square wave.

Every input passes through a two-flop synchronizer. It can then be inverted before both the data-in view and the interrupt logic see it. Inversion lets rising-edge and active-high detectors also serve falling-edge and active-low sources.

Each pin has one cause bit. An edge mask and a level mask gate that cause bit. Pending causes are ORed into one active-high summary line per group of eight pins. The port sits on a plain 32-bit write strobe and read bus, with combinational read data.

Top module: `gpio_port`

## Requirements
- R1: After reset every register is 0 except the direction register of each bank, which is all ones. All pins therefore sense, `pinOutEn` is 0 and `groupIrq` is 0.
- R2: A direction bit of 1 makes the pin an input (`pinOutEn` bit 0). A 0 makes the pin drive (`pinOutEn` bit 1), and `pinOut` then carries the data-out bit.
- R3: Bank b occupies byte offsets 0x40*b to 0x40*b+0x1F. Within a bank the registers are:
  - 0x00 direction
  - 0x04 data-out
  - 0x08 blink enable
  - 0x0C invert
  - 0x10 data-in (read-only, writes ignored)
  - 0x14 edge mask
  - 0x18 level mask
  - 0x1C cause

  Bit i of bank b is pin 32*b+i. Address bits [1:0] are ignored. Offsets 0x20 to 0x3F of a window, and banks at or above the bank count, read 0 and ignore writes.
- R4: Data-in shows a pin change after exactly two clock edges, XORed with that pin's invert bit.
- R5: A driving pin with its blink bit set outputs a shared phase that toggles once every 2^BLINK_BITS cycles, in place of its data-out bit.
- R6: A 0-to-1 transition of the synchronized, inverted-as-configured input sets the pin's cause bit, whatever the mask settings.
- R7: While a pin's level mask bit is 1 and its adjusted input is 1, its cause bit is set every cycle, so a clear does not hold.
- R8: Writing the cause register clears the bits written as 0 and keeps the bits written as 1. A set event in the same cycle wins over the clear.
- R9: `groupIrq[g]` is 1 exactly when a pin in 8g to 8g+7 has its cause bit set together with its edge or level mask bit. Group g lives in bank g/4, byte lane g%4.
- R10: Setting the invert bit turns a falling pin into a rising adjusted input, so an edge interrupt fires on a 1-to-0 pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| pinIn | input | 32*NUM_BANKS | Raw pin levels from the pads |
| pinOut | output | 32*NUM_BANKS | Value to drive on each pin |
| pinOutEn | output | 32*NUM_BANKS | 1 where the pin driver is on |
| groupIrq | output | 4*NUM_BANKS | Active-high summary interrupt per eight-pin group |

## Verification
The data-in path is tried with a table of pin patterns and invert masks across both banks. Mixed-polarity entries show that the invert is applied per bit, not per word or per byte. Interrupts are driven by single-pin rises with and without a mask, which separates cause capture from pending gating. A held level under a clear separates level behaviour from edge behaviour, and a partial clear word exercises the keep-on-1 rule. Falling-edge sensing through the invert bit and a two-group pattern spread over both banks confirm the group-to-bank lane mapping.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BANK_PINS  = 32;
  localparam int GROUP_PINS = 8;
  localparam int WINDOW_LSB = 6;  // bank window is 64 bytes

  typedef enum logic [2:0] {
    SEL_DIR   = 3'd0,
    SEL_DOUT  = 3'd1,
    SEL_BLINK = 3'd2,
    SEL_INV   = 3'd3,
    SEL_DIN   = 3'd4,
    SEL_EMASK = 3'd5,
    SEL_LMASK = 3'd6,
    SEL_CAUSE = 3'd7
  } regSelE;

  typedef struct packed {
    logic   hit;   // address decodes to an existing register
    logic   wr;    // write strobe
    regSelE sel;   // register within the bank
  } busStrobeT;
endpackage

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  parameter int BANK_W    = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStrobeT         strobe,
  output logic [BANK_W-1:0] bankIdx
);
  localparam int UPPER_W = ADDR_W - WINDOW_LSB;
  localparam logic [UPPER_W:0] BANK_LIMIT = (UPPER_W + 1)'(NUM_BANKS);

  logic [UPPER_W-1:0] upperBits;
  logic               bankOk;
  logic               unusedAddrBits;

  assign upperBits      = busAddr[ADDR_W-1:WINDOW_LSB];
  assign bankOk         = ({1'b0, upperBits} < BANK_LIMIT);
  assign bankIdx        = upperBits[BANK_W-1:0];
  assign unusedAddrBits = ^busAddr[1:0];

  always_comb begin
    strobe.hit = bankOk && !busAddr[5];
    strobe.wr  = busWrEn;
    strobe.sel = regSelE'(busAddr[4:2]);
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BLINK_BITS = 24,
  parameter int BANK_W     = 1,
  localparam int NUM_PINS   = NUM_BANKS * BANK_PINS,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_PINS,
  localparam int LANES      = BANK_PINS / GROUP_PINS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobeT             strobe,
  input  logic [BANK_W-1:0]     bankIdx,
  input  logic [31:0]           busWrData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [31:0]           busRdData,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOutEn,
  output logic [NUM_GROUPS-1:0] groupIrq,
  output logic [NUM_PINS-1:0]   adjIn,
  output logic [NUM_PINS-1:0]   causeBits,
  output logic [NUM_PINS-1:0]   edgeMaskBits,
  output logic [NUM_PINS-1:0]   levelMaskBits
);
  logic [BLINK_BITS-1:0] blinkCnt;
  logic                  blinkPhase;
  logic [NUM_PINS-1:0]   rdFlat;

  // one shared divider for every blinking pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blinkCnt   <= '0;
      blinkPhase <= 1'b0;
    end else begin
      blinkCnt <= blinkCnt + 1'b1;
      if (&blinkCnt) blinkPhase <= ~blinkPhase;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic [31:0] dirR, doutR, blinkR, invR, emaskR, lmaskR, causeR;
    logic [31:0] syncA, syncB, prevAdj;
    logic [31:0] adjB, riseB, setB, pendB, rdWord;
    logic        bankWr;

    assign bankWr = strobe.hit && strobe.wr && (bankIdx == BANK_W'(b));
    assign adjB   = syncB ^ invR;
    assign riseB  = adjB & ~prevAdj;
    assign setB   = riseB | (adjB & lmaskR);
    assign pendB  = causeR & (emaskR | lmaskR);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirR    <= '1;
        doutR   <= '0;
        blinkR  <= '0;
        invR    <= '0;
        emaskR  <= '0;
        lmaskR  <= '0;
        causeR  <= '0;
        syncA   <= '0;
        syncB   <= '0;
        prevAdj <= '0;
      end else begin
        if (bankWr && strobe.sel == SEL_DIR)   dirR   <= busWrData;
        if (bankWr && strobe.sel == SEL_DOUT)  doutR  <= busWrData;
        if (bankWr && strobe.sel == SEL_BLINK) blinkR <= busWrData;
        if (bankWr && strobe.sel == SEL_INV)   invR   <= busWrData;
        if (bankWr && strobe.sel == SEL_EMASK) emaskR <= busWrData;
        if (bankWr && strobe.sel == SEL_LMASK) lmaskR <= busWrData;
        // zeros clear, ones keep; a new event outranks the clear
        causeR  <= ((bankWr && strobe.sel == SEL_CAUSE) ? (causeR & busWrData) : causeR) | setB;
        syncA   <= pinIn[b*BANK_PINS +: BANK_PINS];
        syncB   <= syncA;
        prevAdj <= adjB;
      end
    end

    always_comb begin
      unique case (strobe.sel)
        SEL_DIR:   rdWord = dirR;
        SEL_DOUT:  rdWord = doutR;
        SEL_BLINK: rdWord = blinkR;
        SEL_INV:   rdWord = invR;
        SEL_DIN:   rdWord = adjB;
        SEL_EMASK: rdWord = emaskR;
        SEL_LMASK: rdWord = lmaskR;
        SEL_CAUSE: rdWord = causeR;
        default:   rdWord = '0;
      endcase
    end

    assign rdFlat[b*BANK_PINS +: BANK_PINS]        = rdWord;
    assign pinOutEn[b*BANK_PINS +: BANK_PINS]      = ~dirR;
    assign pinOut[b*BANK_PINS +: BANK_PINS]        = (doutR & ~blinkR) | ({32{blinkPhase}} & blinkR);
    assign adjIn[b*BANK_PINS +: BANK_PINS]         = adjB;
    assign causeBits[b*BANK_PINS +: BANK_PINS]     = causeR;
    assign edgeMaskBits[b*BANK_PINS +: BANK_PINS]  = emaskR;
    assign levelMaskBits[b*BANK_PINS +: BANK_PINS] = lmaskR;

    for (genvar k = 0; k < LANES; k++) begin : gLane
      assign groupIrq[b*LANES + k] = |pendB[k*GROUP_PINS +: GROUP_PINS];
    end
  end

  assign busRdData = strobe.hit ? rdFlat[bankIdx*BANK_PINS +: BANK_PINS] : 32'h0;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int ADDR_W     = 8,
  parameter int BLINK_BITS = 24,
  localparam int NUM_PINS   = NUM_BANKS * BANK_PINS,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_PINS,
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOutEn,
  output logic [NUM_GROUPS-1:0] groupIrq
);
  busStrobeT           strobe;
  logic [BANK_W-1:0]   bankIdx;
  logic [NUM_PINS-1:0] adjIn, causeBits, edgeMaskBits, levelMaskBits;

  gpio_bus_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .strobe(strobe), .bankIdx(bankIdx)
  );

  gpio_datapath #(.NUM_BANKS(NUM_BANKS), .BLINK_BITS(BLINK_BITS), .BANK_W(BANK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bankIdx(bankIdx), .busWrData(busWrData),
    .pinIn(pinIn), .busRdData(busRdData), .pinOut(pinOut), .pinOutEn(pinOutEn),
    .groupIrq(groupIrq), .adjIn(adjIn), .causeBits(causeBits),
    .edgeMaskBits(edgeMaskBits), .levelMaskBits(levelMaskBits)
  );
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int NUM_PINS   = NUM_BANKS * BANK_PINS,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_PINS
) (
  input logic                  clk,
  input logic                  rstN,
  input busStrobeT             strobe,
  input logic [31:0]           busRdData,
  input logic [NUM_PINS-1:0]   pinOutEn,
  input logic [NUM_GROUPS-1:0] groupIrq,
  input logic [NUM_PINS-1:0]   adjIn,
  input logic [NUM_PINS-1:0]   causeBits,
  input logic [NUM_PINS-1:0]   edgeMaskBits,
  input logic [NUM_PINS-1:0]   levelMaskBits
);
  logic [NUM_PINS-1:0] adjPrev, riseVec, levelVec;
  logic                causeWr, dirWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) adjPrev <= '0;
    else       adjPrev <= adjIn;
  end

  assign riseVec  = adjIn & ~adjPrev;
  assign levelVec = adjIn & levelMaskBits;
  assign causeWr  = strobe.hit && strobe.wr && strobe.sel == SEL_CAUSE;
  assign dirWr    = strobe.hit && strobe.wr && strobe.sel == SEL_DIR;

  assert_unmapped_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.hit |-> busRdData == 32'h0);

  assert_outen_needs_dir_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !dirWr |=> $stable(pinOutEn));

  assert_edge_sets_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    riseVec != '0 |=> (causeBits & $past(riseVec)) == $past(riseVec));

  assert_level_sets_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    levelVec != '0 |=> (causeBits & $past(levelVec)) == $past(levelVec));

  assert_cause_kept_without_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    !causeWr |=> (causeBits & $past(causeBits)) == $past(causeBits));

  assert_irq_needs_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    groupIrq != '0 |-> (causeBits & (edgeMaskBits | levelMaskBits)) != '0);
endmodule

bind gpio_port gpio_port_checker #(.NUM_BANKS(NUM_BANKS)) u_checker (
  .clk(clk), .rstN(rstN), .strobe(strobe), .busRdData(busRdData), .pinOutEn(pinOutEn),
  .groupIrq(groupIrq), .adjIn(adjIn), .causeBits(causeBits),
  .edgeMaskBits(edgeMaskBits), .levelMaskBits(levelMaskBits)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] busRdData;
  logic [63:0] pinIn = 64'h0;
  logic [63:0] pinOut, pinOutEn;
  logic [7:0]  groupIrq;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_port #(.NUM_BANKS(2), .ADDR_W(8), .BLINK_BITS(4)) u_gpio_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn),
    .groupIrq(groupIrq)
  );

  // {invert bank0, pin pattern per bank, expected bank0 data-in}
  localparam logic [95:0] DIN_TABLE [5] = '{
    {32'h0000_0000, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h0000_FFFF, 32'h1234_5678, 32'h1234_A987},
    {32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0},
    {32'h8000_0001, 32'h8000_0001, 32'h0000_0000}
  };

  task automatic checkEq(input logic [63:0] act, input logic [63:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic setPins(input logic [63:0] v, input int settle);
    @(negedge clk);
    pinIn = v;
    repeat (settle) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] d2;
    logic        lastBit;
    int          gap;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h00, d); checkEq(d, 32'hFFFF_FFFF, "R1 bank0 direction");
    rd(8'h40, d); checkEq(d, 32'hFFFF_FFFF, "R1 bank1 direction");
    rd(8'h04, d); checkEq(d, 0, "R1 data-out");
    rd(8'h5C, d); checkEq(d, 0, "R1 cause");
    checkEq(pinOutEn, 0, "R1 pinOutEn");
    checkEq(groupIrq, 0, "R1 groupIrq");

    // R2 direction and data-out
    wr(8'h00, 32'hFFFF_0000);
    wr(8'h04, 32'h0000_A55A);
    wr(8'h40, 32'h7FFF_FFFF);
    wr(8'h44, 32'h8000_0000);
    checkEq(pinOutEn, 64'h8000_0000_0000_FFFF, "R2 pinOutEn");
    checkEq(pinOut[15:0], 16'hA55A, "R2 bank0 drive");
    checkEq(pinOut[63], 1'b1, "R2 pin63 drive");

    // R3 decode corners
    rd(8'h06, d); checkEq(d, 32'h0000_A55A, "R3 low address bits ignored");
    wr(8'h20, 32'h0);
    rd(8'h20, d); checkEq(d, 0, "R3 hole reads zero");
    rd(8'h00, d); checkEq(d, 32'hFFFF_0000, "R3 hole write ignored");
    wr(8'h80, 32'h0);
    rd(8'h80, d); checkEq(d, 0, "R3 missing bank reads zero");
    rd(8'h00, d); checkEq(d, 32'hFFFF_0000, "R3 missing bank write ignored");
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, d); checkEq(d, 0, "R3 data-in write ignored");

    // R4 exact synchronizer latency
    @(negedge clk); busAddr = 8'h10;
    pinIn = 64'h0000_0000_0000_00F0;
    @(negedge clk); #1 checkEq(busRdData, 0, "R4 one edge still old");
    @(negedge clk); #1 checkEq(busRdData, 32'hF0, "R4 two edges new value");

    // R4 table of patterns and invert masks
    for (int i = 0; i < 5; i++) begin
      wr(8'h0C, DIN_TABLE[i][95:64]);
      setPins({DIN_TABLE[i][63:32], DIN_TABLE[i][63:32]}, 3);
      rd(8'h10, d); checkEq(d, DIN_TABLE[i][31:0], "R4 bank0 inverted data-in");
      rd(8'h50, d); checkEq(d, DIN_TABLE[i][63:32], "R4 bank1 data-in");
    end

    // R5 blink: pin0 blinks, pin1 holds data-out
    wr(8'h08, 32'h1);
    lastBit = pinOut[0];
    gap = 0;
    while (pinOut[0] == lastBit && gap < 40) begin @(negedge clk); gap++; end
    for (int n = 0; n < 2; n++) begin
      lastBit = pinOut[0];
      gap = 0;
      while (pinOut[0] == lastBit && gap < 40) begin @(negedge clk); gap++; end
      checkEq(gap, 16, "R5 blink half period");
    end
    checkEq(pinOut[1], 1'b1, "R5 non-blink pin holds data-out");
    checkEq(pinOutEn[0], 1'b1, "R5 blink pin still driving");
    wr(8'h08, 32'h0);

    // interrupt setup: clean state
    wr(8'h0C, 32'h0);
    setPins(64'h0, 4);
    wr(8'h1C, 32'h0);
    wr(8'h5C, 32'h0);
    checkEq(groupIrq, 0, "R9 idle no interrupt");

    // R6 masked edge on pin 8 -> group 1
    wr(8'h14, 32'h0000_0100);
    setPins(64'h100, 4);
    checkEq(groupIrq, 8'h02, "R6 edge raises group1");
    rd(8'h1C, d); checkEq(d, 32'h100, "R6 cause bit 8");
    setPins(64'h0, 4);
    checkEq(groupIrq, 8'h02, "R6 edge cause latched after pin drop");
    wr(8'h1C, 32'hFFFF_FEFF);
    checkEq(groupIrq, 0, "R8 clear removes interrupt");

    // R6/R9 unmasked edge still records cause
    setPins(64'h200, 4);
    rd(8'h1C, d); checkEq(d, 32'h200, "R6 unmasked edge cause");
    checkEq(groupIrq, 0, "R9 unmasked cause gives no interrupt");

    // R8 keep-on-one
    setPins(64'h20C, 4);
    wr(8'h1C, 32'hFFFF_FFF7);
    rd(8'h1C, d); checkEq(d, 32'h204, "R8 only zero bits cleared");
    wr(8'h1C, 32'h0);
    setPins(64'h0, 3);

    // R7 level on pin 40 -> group 5
    wr(8'h58, 32'h100);
    setPins(64'h1 << 40, 4);
    checkEq(groupIrq, 8'h20, "R7 level raises group5");
    wr(8'h5C, 32'h0);
    rd(8'h5C, d2); checkEq(d2, 32'h100, "R7 level cause reasserts");
    setPins(64'h0, 4);
    wr(8'h5C, 32'h0);
    checkEq(groupIrq, 0, "R7 cleared once level inactive");
    wr(8'h58, 32'h0);

    // R10 falling edge through invert on pin 16 -> group 2
    setPins(64'h1 << 16, 4);
    wr(8'h0C, 32'h0001_0000);
    wr(8'h1C, 32'h0);
    wr(8'h14, 32'h0001_0000);
    checkEq(groupIrq, 0, "R10 no interrupt while pin high");
    setPins(64'h0, 4);
    checkEq(groupIrq, 8'h04, "R10 falling pin raises group2");
    rd(8'h10, d); checkEq(d[16], 1'b1, "R10 inverted data-in");

    // R9 group mapping across banks: pins 24 and 63
    wr(8'h14, 32'h0100_0000);
    wr(8'h54, 32'h8000_0000);
    wr(8'h1C, 32'h0);
    wr(8'h5C, 32'h0);
    setPins((64'h1 << 24) | (64'h1 << 63), 4);
    checkEq(groupIrq, 8'h88, "R9 groups 3 and 7");

    summary();
    $finish;
  end
endmodule